// File: doc/BRIEF.md
# Four-bit ECC parity packer and correction sequencer

This block works beside a sector ECC engine that can repair up to four bad bytes in a 512-byte sector. When a sector is written, it takes the eight 10-bit parity symbols the engine leaves in four 32-bit registers and turns them into ten spare-area bytes. The bytes leave on a valid/ready byte stream. When a sector is read, it takes the ten stored spare bytes from a second byte stream and splits them back into eight symbols. It loads those symbols into the engine, checks the syndromes and, when the syndromes are not all zero, runs the engine's correction handshake. Each error the engine reports becomes an XOR patch (a byte offset and a mask) on a third valid/ready stream. The owner of the sector buffer applies each patch.

Both streams follow the usual rules. A transfer happens on a clock edge where valid and ready are both high. A producer that raises valid keeps it high, with its data unchanged, until the transfer happens. The read-side input (`st_ready_o`) only accepts bytes while the sequencer is idle. It drops as soon as the tenth byte of a sector has arrived, and it rises again after the result has been reported. The packed-parity output and the patch output both accept back-pressure for any number of cycles. Each sector ends with a one-cycle `done_o` pulse that carries the number of patches emitted and an uncorrectable flag.

Top module: `rs4_ecc_fixup`

## Requirements
- R1: Parity register k (bits [32k+31:32k] of `eng_regs_i`) gives symbol 2k from its bits [9:0] and symbol 2k+1 from its bits [25:16]. No other register bit affects the packed bytes.
- R2: The eight symbols are joined into an 80-bit field, with symbol s at bits [10s+9:10s]. This field leaves as ten bytes, and byte j carries field bits [8j+7:8j]. `pk_last_o` is high on the tenth byte only.
- R3: While `pk_valid_o` is high and `pk_ready_i` is low, `pk_valid_o`, `pk_data_o` and `pk_last_o` hold their values.
- R4: If all ten stored bytes are 0xFF, the sector is reported with zero patches and no failure. No symbol is loaded and no correction is started.
- R5: Otherwise the stored bytes are read as a little-endian 80-bit field with symbol s at bits [10s+9:10s]. The eight symbols are loaded one per cycle on `eng_load_valid_o`, symbol 7 first and symbol 0 last.
- R6: If the four syndrome registers, each masked to bits [9:0] and [25:16], are all zero after loading, the sector is reported with zero patches. No correction is started.
- R7: Otherwise `eng_start_o` pulses for one cycle, and then `eng_state_i` is polled. A value of 0 reports zero patches. A value of 1 reports the sector as uncorrectable. Values of 4 and above mean the engine is still busy.
- R8: A status of 2 or 3 means the engine is done, and the error count is 1 + `eng_count_i`. Errors 0 and 1 use the low 32-bit address/value registers, and errors 2 and 3 use the high ones. Even-numbered errors use bits [15:0] of their register and odd-numbered errors use bits [31:16].
- R9: The raw address is the low 10 bits of the selected half, and the byte offset is 519 minus that raw value. A patch is emitted only when the offset lies in 0..511. The patch mask is the low 8 bits of the selected value half.
- R10: `done_fixed_o` equals the number of patches transferred for the sector, which is at most four.
- R11: If the status stays at 4 or above for POLL_LIMIT consecutive polls, the sector is reported as uncorrectable with zero patches.
- R12: While `fix_valid_o` is high and `fix_ready_i` is low, the patch offset and mask hold, and `fix_valid_o` stays high.
- R13: `st_ready_o` is high only while the sequencer is idle with fewer than ten bytes collected. It is low while symbols are being loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pack_start_i | input | 1 | Capture the parity registers and begin emitting bytes |
| eng_regs_i | input | 128 | Engine parity / syndrome registers, four of 32 bits |
| pk_valid_o | output | 1 | Packed parity byte valid |
| pk_ready_i | input | 1 | Packed parity byte ready |
| pk_data_o | output | 8 | Packed parity byte |
| pk_last_o | output | 1 | Tenth packed byte |
| st_valid_i | input | 1 | Stored spare byte valid |
| st_ready_o | output | 1 | Stored spare byte ready |
| st_data_i | input | 8 | Stored spare byte |
| eng_load_valid_o | output | 1 | Symbol load strobe to the engine |
| eng_load_sym_o | output | 10 | Symbol being loaded |
| eng_start_o | output | 1 | Start-correction pulse |
| eng_state_i | input | 4 | Engine correction status |
| eng_count_i | input | 2 | Error count minus one |
| eng_err_addr_i | input | 64 | Two error address registers |
| eng_err_val_i | input | 64 | Two error value registers |
| fix_valid_o | output | 1 | Patch valid |
| fix_ready_i | input | 1 | Patch ready |
| fix_offset_o | output | 9 | Byte offset in the sector |
| fix_mask_o | output | 8 | XOR mask for that byte |
| done_o | output | 1 | Sector result pulse |
| done_fixed_o | output | 3 | Patches emitted for the sector |
| done_fail_o | output | 1 | Sector uncorrectable |

## Verification
The bench builds the block with POLL_LIMIT set to 16. With that limit, a sector whose busy status lasts 15 polls and one whose busy status lasts 16 polls can be placed on either side of the timeout. The small limit also leaves room to sweep every one of the 1024 raw error address values, so both ends of the 519-minus-address window and the wrap above it are covered. Every single-bit position of the 80-bit parity field is walked through the packer. Error counts one to four are run with back-pressure on both output streams.

// File: rtl/rs4_pkg.sv
package rs4_pkg;
  localparam int SYM_W     = 10;
  localparam int NUM_SYM   = 8;
  localparam int FIELD_W   = SYM_W * NUM_SYM;
  localparam int NUM_BYTES = FIELD_W / 8;
  localparam int REG_W     = 32;
  localparam int HALF_W    = REG_W / 2;
  localparam int NUM_REG   = NUM_SYM / 2;
  localparam int SECTOR_BYTES = 512;
  localparam int OFFS_BIAS = SECTOR_BYTES + 7;
  localparam int OFFS_W    = $clog2(SECTOR_BYTES);
  localparam int DIFF_W    = SYM_W + 1;
  localparam int BIDX_W    = $clog2(NUM_BYTES);
  localparam int SIDX_W    = $clog2(NUM_SYM);

  localparam logic [REG_W-1:0] SYM_ONES = REG_W'((1 << SYM_W) - 1);
  localparam logic [REG_W-1:0] REG_KEEP = SYM_ONES | (SYM_ONES << HALF_W);
  localparam logic [NUM_REG*REG_W-1:0] REGS_KEEP = {NUM_REG{REG_KEEP}};

  localparam logic [3:0] STAT_CLEAN = 4'd0;
  localparam logic [3:0] STAT_FAIL  = 4'd1;
  localparam logic [3:0] STAT_DONE0 = 4'd2;
  localparam logic [3:0] STAT_DONE1 = 4'd3;

  typedef enum logic [2:0] {
    S_COLLECT, S_EXAM, S_LOAD, S_SYN, S_START, S_POLL, S_APPLY, S_REPORT
  } seq_state_t;
endpackage

// File: rtl/rs4_packer.sv
module rs4_packer
  import rs4_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [NUM_REG*REG_W-1:0] regs_i,
  output logic                     valid_o,
  input  logic                     ready_i,
  output logic [7:0]               data_o,
  output logic                     last_o
);
  logic [FIELD_W-1:0] field_d, field_q;
  logic [BIDX_W-1:0]  idx_q;
  logic               valid_q;
  logic               unused_bits;

  assign unused_bits = ^(regs_i & ~REGS_KEEP);

  for (genvar k = 0; k < NUM_REG; k++) begin : g_gather
    assign field_d[(2*k)*SYM_W +: SYM_W]   = regs_i[k*REG_W +: SYM_W];
    assign field_d[(2*k+1)*SYM_W +: SYM_W] = regs_i[k*REG_W+HALF_W +: SYM_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q <= '0;
      idx_q   <= '0;
      valid_q <= 1'b0;
    end else if (!valid_q) begin
      if (start_i) begin
        field_q <= field_d;
        idx_q   <= '0;
        valid_q <= 1'b1;
      end
    end else if (ready_i) begin
      field_q <= field_q >> 8;
      if (idx_q == BIDX_W'(NUM_BYTES - 1)) valid_q <= 1'b0;
      else idx_q <= idx_q + 1'b1;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = field_q[7:0];
  assign last_o  = valid_q && (idx_q == BIDX_W'(NUM_BYTES - 1));
endmodule

// File: rtl/rs4_unpacker.sv
module rs4_unpacker
  import rs4_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic               clear_i,
  input  logic               valid_i,
  output logic               ready_o,
  input  logic [7:0]         data_i,
  output logic               full_o,
  output logic               erased_o,
  output logic [FIELD_W-1:0] field_o
);
  logic [FIELD_W-1:0] field_q;
  logic [BIDX_W-1:0]  cnt_q;
  logic               full_q;
  logic               all_ff_q;

  assign ready_o = en_i && !full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q  <= '0;
      cnt_q    <= '0;
      full_q   <= 1'b0;
      all_ff_q <= 1'b1;
    end else if (clear_i) begin
      cnt_q    <= '0;
      full_q   <= 1'b0;
      all_ff_q <= 1'b1;
    end else if (valid_i && ready_o) begin
      field_q[{cnt_q, 3'b000} +: 8] <= data_i;
      all_ff_q <= all_ff_q && (data_i == 8'hFF);
      if (cnt_q == BIDX_W'(NUM_BYTES - 1)) full_q <= 1'b1;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

  assign full_o   = full_q;
  assign erased_o = all_ff_q;
  assign field_o  = field_q;
endmodule

// File: rtl/rs4_err_pick.sv
module rs4_err_pick
  import rs4_pkg::*;
(
  input  logic [1:0]         idx_i,
  input  logic [2*REG_W-1:0] addr_regs_i,
  input  logic [2*REG_W-1:0] val_regs_i,
  output logic               hit_o,
  output logic [OFFS_W-1:0]  offs_o,
  output logic [7:0]         mask_o
);
  logic [REG_W-1:0]  a_reg, v_reg;
  logic [HALF_W-1:0] a_half, v_half;
  logic [SYM_W-1:0]  raw;
  logic [DIFF_W-1:0] diff;
  logic              unused_pick;

  assign a_reg  = idx_i[1] ? addr_regs_i[REG_W +: REG_W] : addr_regs_i[0 +: REG_W];
  assign v_reg  = idx_i[1] ? val_regs_i[REG_W +: REG_W]  : val_regs_i[0 +: REG_W];
  assign a_half = idx_i[0] ? a_reg[HALF_W +: HALF_W] : a_reg[0 +: HALF_W];
  assign v_half = idx_i[0] ? v_reg[HALF_W +: HALF_W] : v_reg[0 +: HALF_W];
  assign raw    = a_half[SYM_W-1:0];
  assign diff   = DIFF_W'(OFFS_BIAS) - {1'b0, raw};
  assign hit_o  = (diff < DIFF_W'(SECTOR_BYTES));
  assign offs_o = diff[OFFS_W-1:0];
  assign mask_o = v_half[7:0];
  assign unused_pick = ^{a_half[HALF_W-1:SYM_W], v_half[HALF_W-1:8], diff[DIFF_W-1:OFFS_W]};
endmodule

// File: rtl/rs4_fix_seq.sv
module rs4_fix_seq
  import rs4_pkg::*;
#(
  parameter int POLL_LIMIT = 4096,
  localparam int TMR_W = $clog2(POLL_LIMIT + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     full_i,
  input  logic                     erased_i,
  input  logic [FIELD_W-1:0]       field_i,
  output logic                     collect_o,
  output logic                     clear_o,
  input  logic [NUM_REG*REG_W-1:0] syn_regs_i,
  output logic                     load_valid_o,
  output logic [SYM_W-1:0]         load_sym_o,
  output logic                     start_o,
  input  logic [3:0]               stat_i,
  input  logic [1:0]               cnt_i,
  input  logic [2*REG_W-1:0]       addr_i,
  input  logic [2*REG_W-1:0]       val_i,
  output logic [1:0]               pick_idx_o,
  output logic [2*REG_W-1:0]       addr_q_o,
  output logic [2*REG_W-1:0]       val_q_o,
  input  logic                     hit_i,
  output logic                     fix_valid_o,
  input  logic                     fix_ready_i,
  output logic                     done_o,
  output logic [2:0]               done_fixed_o,
  output logic                     done_fail_o
);
  seq_state_t         st_q;
  logic [SIDX_W-1:0]  sym_q;
  logic [TMR_W-1:0]   tmr_q;
  logic [1:0]         eidx_q;
  logic [2:0]         ecnt_q;
  logic [2:0]         fixed_q;
  logic               fail_q;
  logic [2*REG_W-1:0] addr_q, val_q;
  logic               last_err;
  logic               syn_zero;

  assign last_err = ({1'b0, eidx_q} == (ecnt_q - 3'd1));
  assign syn_zero = ((syn_regs_i & REGS_KEEP) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_COLLECT;
      sym_q   <= '0;
      tmr_q   <= '0;
      eidx_q  <= '0;
      ecnt_q  <= '0;
      fixed_q <= '0;
      fail_q  <= 1'b0;
      addr_q  <= '0;
      val_q   <= '0;
    end else begin
      case (st_q)
        S_COLLECT: if (full_i) st_q <= S_EXAM;
        S_EXAM: begin
          fixed_q <= '0;
          fail_q  <= 1'b0;
          if (erased_i) st_q <= S_REPORT;
          else begin
            sym_q <= SIDX_W'(NUM_SYM - 1);
            st_q  <= S_LOAD;
          end
        end
        S_LOAD: begin
          if (sym_q == '0) st_q <= S_SYN;
          else sym_q <= sym_q - 1'b1;
        end
        S_SYN: st_q <= syn_zero ? S_REPORT : S_START;
        S_START: begin
          tmr_q <= '0;
          st_q  <= S_POLL;
        end
        S_POLL: begin
          case (stat_i)
            STAT_CLEAN: st_q <= S_REPORT;
            STAT_FAIL: begin
              fail_q <= 1'b1;
              st_q   <= S_REPORT;
            end
            STAT_DONE0, STAT_DONE1: begin
              addr_q <= addr_i;
              val_q  <= val_i;
              ecnt_q <= 3'd1 + {1'b0, cnt_i};
              eidx_q <= '0;
              st_q   <= S_APPLY;
            end
            default: begin
              if (tmr_q == TMR_W'(POLL_LIMIT - 1)) begin
                fail_q <= 1'b1;
                st_q   <= S_REPORT;
              end else tmr_q <= tmr_q + 1'b1;
            end
          endcase
        end
        S_APPLY: begin
          if (!hit_i || fix_ready_i) begin
            if (hit_i) fixed_q <= fixed_q + 3'd1;
            if (last_err) st_q <= S_REPORT;
            else eidx_q <= eidx_q + 2'd1;
          end
        end
        S_REPORT: st_q <= S_COLLECT;
        default:  st_q <= S_COLLECT;
      endcase
    end
  end

  assign collect_o    = (st_q == S_COLLECT);
  assign clear_o      = (st_q == S_REPORT);
  assign load_valid_o = (st_q == S_LOAD);
  assign load_sym_o   = field_i[SYM_W*int'(sym_q) +: SYM_W];
  assign start_o      = (st_q == S_START);
  assign pick_idx_o   = eidx_q;
  assign addr_q_o     = addr_q;
  assign val_q_o      = val_q;
  assign fix_valid_o  = (st_q == S_APPLY) && hit_i;
  assign done_o       = (st_q == S_REPORT);
  assign done_fixed_o = done_o ? fixed_q : 3'd0;
  assign done_fail_o  = done_o && fail_q;
endmodule

// File: rtl/rs4_ecc_fixup.sv
module rs4_ecc_fixup
  import rs4_pkg::*;
#(
  parameter int POLL_LIMIT = 4096
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pack_start_i,
  input  logic [127:0] eng_regs_i,
  output logic         pk_valid_o,
  input  logic         pk_ready_i,
  output logic [7:0]   pk_data_o,
  output logic         pk_last_o,
  input  logic         st_valid_i,
  output logic         st_ready_o,
  input  logic [7:0]   st_data_i,
  output logic         eng_load_valid_o,
  output logic [9:0]   eng_load_sym_o,
  output logic         eng_start_o,
  input  logic [3:0]   eng_state_i,
  input  logic [1:0]   eng_count_i,
  input  logic [63:0]  eng_err_addr_i,
  input  logic [63:0]  eng_err_val_i,
  output logic         fix_valid_o,
  input  logic         fix_ready_i,
  output logic [8:0]   fix_offset_o,
  output logic [7:0]   fix_mask_o,
  output logic         done_o,
  output logic [2:0]   done_fixed_o,
  output logic         done_fail_o
);
  logic               full, erased, collect, clear, hit;
  logic [FIELD_W-1:0] field;
  logic [1:0]         pick_idx;
  logic [63:0]        addr_q, val_q;

  rs4_packer i_packer (
    .clk(clk), .rst_n(rst_n), .start_i(pack_start_i), .regs_i(eng_regs_i),
    .valid_o(pk_valid_o), .ready_i(pk_ready_i), .data_o(pk_data_o), .last_o(pk_last_o)
  );

  rs4_unpacker i_unpacker (
    .clk(clk), .rst_n(rst_n), .en_i(collect), .clear_i(clear),
    .valid_i(st_valid_i), .ready_o(st_ready_o), .data_i(st_data_i),
    .full_o(full), .erased_o(erased), .field_o(field)
  );

  rs4_fix_seq #(.POLL_LIMIT(POLL_LIMIT)) i_seq (
    .clk(clk), .rst_n(rst_n), .full_i(full), .erased_i(erased), .field_i(field),
    .collect_o(collect), .clear_o(clear), .syn_regs_i(eng_regs_i),
    .load_valid_o(eng_load_valid_o), .load_sym_o(eng_load_sym_o), .start_o(eng_start_o),
    .stat_i(eng_state_i), .cnt_i(eng_count_i), .addr_i(eng_err_addr_i), .val_i(eng_err_val_i),
    .pick_idx_o(pick_idx), .addr_q_o(addr_q), .val_q_o(val_q), .hit_i(hit),
    .fix_valid_o(fix_valid_o), .fix_ready_i(fix_ready_i),
    .done_o(done_o), .done_fixed_o(done_fixed_o), .done_fail_o(done_fail_o)
  );

  rs4_err_pick i_pick (
    .idx_i(pick_idx), .addr_regs_i(addr_q), .val_regs_i(val_q),
    .hit_o(hit), .offs_o(fix_offset_o), .mask_o(fix_mask_o)
  );
endmodule

// File: rtl/rs4_ecc_chk.sv
module rs4_ecc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pk_valid_o,
  input logic       pk_ready_i,
  input logic [7:0] pk_data_o,
  input logic       pk_last_o,
  input logic       st_ready_o,
  input logic       eng_load_valid_o,
  input logic       eng_start_o,
  input logic       fix_valid_o,
  input logic       fix_ready_i,
  input logic [8:0] fix_offset_o,
  input logic [7:0] fix_mask_o,
  input logic       done_o,
  input logic [2:0] done_fixed_o,
  input logic       done_fail_o
);
  AST_PK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pk_valid_o && !pk_ready_i |=> pk_valid_o && $stable(pk_data_o) && $stable(pk_last_o)); // R3

  AST_FIX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fix_valid_o && !fix_ready_i |=> fix_valid_o && $stable(fix_offset_o) && $stable(fix_mask_o)); // R12

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start_o |=> !eng_start_o); // R7

  AST_FAIL_NO_FIX: assert property (@(posedge clk) disable iff (!rst_n)
    done_fail_o |-> done_o && (done_fixed_o == 3'd0)); // R11

  AST_IN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    eng_load_valid_o |-> !st_ready_o); // R13

  AST_FIX_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> done_fixed_o <= 3'd4); // R10
endmodule

bind rs4_ecc_fixup rs4_ecc_chk i_chk (.*);

// File: tb/test_rs4_ecc_fixup.sv
module test_rs4_ecc_fixup;
  localparam int LIM = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pack_start_i = 1'b0;
  logic [127:0] eng_regs_i = '0;
  logic         pk_valid_o, pk_ready_i = 1'b1, pk_last_o;
  logic [7:0]   pk_data_o;
  logic         st_valid_i = 1'b0, st_ready_o;
  logic [7:0]   st_data_i = '0;
  logic         eng_load_valid_o, eng_start_o;
  logic [9:0]   eng_load_sym_o;
  logic [3:0]   eng_state_i = 4'd9;
  logic [1:0]   eng_count_i = '0;
  logic [63:0]  eng_err_addr_i = '0, eng_err_val_i = '0;
  logic         fix_valid_o, fix_ready_i = 1'b1;
  logic [8:0]   fix_offset_o;
  logic [7:0]   fix_mask_o;
  logic         done_o, done_fail_o;
  logic [2:0]   done_fixed_o;

  always #5 clk = ~clk;

  rs4_ecc_fixup #(.POLL_LIMIT(LIM)) i_rs4_ecc_fixup (.*);

  int checks = 0, errors = 0;
  bit summary_done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitors and simple engine model
  logic [15:0] lfsr = 16'hACE1;
  bit          bp_on = 0;
  int          load_n = 0, start_n = 0, fix_n = 0, pk_n = 0;
  logic [9:0]  load_log [16];
  logic [8:0]  fix_off_log [8];
  logic [7:0]  fix_mask_log [8];
  logic [7:0]  pk_log [16];
  logic        pk_last_log [16];
  int          busy_cnt = 0, delay = 2;
  logic [3:0]  tgt_state = 4'd0;
  logic [7:0]  sbytes [10];

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    pk_ready_i  = bp_on ? lfsr[0] : 1'b1;
    fix_ready_i = bp_on ? lfsr[3] : 1'b1;
    if (rst_n) begin
      if (pk_valid_o && pk_ready_i) begin
        if (pk_n < 16) begin pk_log[pk_n] = pk_data_o; pk_last_log[pk_n] = pk_last_o; end
        pk_n++;
      end
      if (fix_valid_o && fix_ready_i) begin
        if (fix_n < 8) begin fix_off_log[fix_n] = fix_offset_o; fix_mask_log[fix_n] = fix_mask_o; end
        fix_n++;
      end
      if (eng_load_valid_o) begin
        if (load_n < 16) load_log[load_n] = eng_load_sym_o;
        load_n++;
      end
    end
    if (eng_start_o) begin start_n++; busy_cnt = delay; end
    else if (busy_cnt > 0) busy_cnt--;
    eng_state_i = (busy_cnt > 0) ? 4'd9 : tgt_state;
  end

  task automatic do_pack(input logic [127:0] regs);
    logic [7:0] exp [10];
    int w;
    for (int j = 0; j < 10; j++)
      for (int b = 0; b < 8; b++) begin
        int p = 8 * j + b;
        int s = p / 10;
        exp[j][b] = regs[32 * (s / 2) + 16 * (s % 2) + (p % 10)];
      end
    pk_n = 0;
    eng_regs_i = regs;
    @(negedge clk); pack_start_i = 1'b1;
    @(negedge clk); pack_start_i = 1'b0;
    w = 0;
    while (pk_n < 10 && w < 200) begin @(negedge clk); w++; end
    repeat (3) @(negedge clk);
    chk(pk_n == 10, "R2", "pack byte count", pk_n, 10);
    for (int j = 0; j < 10; j++) begin
      chk(pk_log[j] == exp[j], "R1", "pack byte", pk_log[j], exp[j]);
      chk(pk_last_log[j] == (j == 9), "R2", "pack last flag", pk_last_log[j], (j == 9));
    end
  endtask

  task automatic do_sector(input logic [127:0] syn, input logic [3:0] tgt,
                           input logic [1:0] cnt, input int dly,
                           input logic [63:0] ea, input logic [63:0] ev, input string req);
    logic [9:0] sym [8];
    logic [8:0] eoff [4];
    logic [7:0] emask [4];
    int  en = 0, w;
    bit  erased = 1, started, efail = 0;
    int  got_fixed;
    bit  got_fail, seen;
    for (int j = 0; j < 10; j++) if (sbytes[j] != 8'hFF) erased = 0;
    for (int s = 0; s < 8; s++)
      for (int b = 0; b < 10; b++) begin
        int p = 10 * s + b;
        sym[s][b] = sbytes[p / 8][p % 8];
      end
    started = !erased && ((syn & {4{32'h03FF03FF}}) != '0);
    if (started) begin
      if (dly > LIM) efail = 1;
      else if (tgt == 4'd1) efail = 1;
      else if (tgt >= 4'd2) begin
        for (int i = 0; i <= int'(cnt); i++) begin
          logic [31:0] r = (i > 1) ? ea[63:32] : ea[31:0];
          logic [31:0] v = (i > 1) ? ev[63:32] : ev[31:0];
          int raw = (i % 2) ? int'(r[25:16]) : int'(r[9:0]);
          int off = 519 - raw;
          if (off >= 0 && off < 512) begin
            eoff[en] = 9'(off);
            emask[en] = (i % 2) ? v[23:16] : v[7:0];
            en++;
          end
        end
      end
    end
    eng_regs_i = syn; tgt_state = tgt; eng_count_i = cnt; delay = dly;
    eng_err_addr_i = ea; eng_err_val_i = ev;
    load_n = 0; start_n = 0; fix_n = 0;
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      st_valid_i = 1'b1; st_data_i = sbytes[j];
      while (!st_ready_o) @(negedge clk);
    end
    @(negedge clk);
    st_valid_i = 1'b0;
    chk(!st_ready_o, "R13", "input ready after tenth byte", st_ready_o, 0);
    w = 0; seen = 0;
    while (!seen && w < 2000) begin
      if (done_o) seen = 1;
      else begin @(negedge clk); w++; end
    end
    got_fixed = int'(done_fixed_o); got_fail = done_fail_o;
    chk(seen, req, "done seen", seen, 1);
    chk(load_n == (erased ? 0 : 8), erased ? "R4" : "R5", "symbol loads", load_n, erased ? 0 : 8);
    if (!erased)
      for (int j = 0; j < 8; j++)
        chk(load_log[j] == sym[7 - j], "R5", "load order", load_log[j], sym[7 - j]);
    chk(start_n == (started ? 1 : 0), started ? "R7" : "R6", "start pulses", start_n, started);
    chk(got_fail == efail, req, "fail flag", got_fail, efail);
    chk(got_fixed == en, req, "fixed count", got_fixed, en);
    chk(fix_n == got_fixed, "R10", "patches vs count", fix_n, got_fixed);
    for (int i = 0; i < en && i < fix_n; i++) begin
      chk(fix_off_log[i] == eoff[i], "R9", "patch offset", fix_off_log[i], eoff[i]);
      chk(fix_mask_log[i] == emask[i], "R8", "patch mask", fix_mask_log[i], emask[i]);
    end
    @(negedge clk);
  endtask

  task automatic fill_bytes(input int seed);
    for (int j = 0; j < 10; j++) sbytes[j] = 8'((seed * 37 + j * 113 + 5) ^ (seed >> 3));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!pk_valid_o && !done_o && !fix_valid_o && !eng_start_o, "R13", "outputs in reset", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(st_ready_o, "R13", "idle input ready", st_ready_o, 1);

    // Packer sweeps (R1, R2, R3)
    do_pack('0);
    do_pack({128{1'b1}});
    for (int s = 0; s < 8; s++)
      for (int b = 0; b < 10; b++) begin
        logic [127:0] r = {4{32'hFC00FC00}};
        r[32 * (s / 2) + 16 * (s % 2) + b] = 1'b1;
        bp_on = (b % 2 == 1);
        do_pack(r);
      end
    bp_on = 1;
    do_pack(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);
    chk(pk_n == 10, "R3", "bytes under back-pressure", pk_n, 10);
    bp_on = 0;

    // Erased sector (R4)
    for (int j = 0; j < 10; j++) sbytes[j] = 8'hFF;
    do_sector({4{32'h00010001}}, 4'd2, 2'd3, 2, 64'h0, 64'h0, "R4");
    // Nearly erased, syndromes zero after masking (R6)
    sbytes[4] = 8'hFE;
    do_sector({4{32'hFC00FC00}}, 4'd2, 2'd0, 2, 64'h0, 64'h0, "R6");

    // Load order with assorted stored bytes (R5, R6)
    for (int k = 0; k < 12; k++) begin
      fill_bytes(k + 1);
      do_sector('0, 4'd2, 2'd0, 2, 64'h0, 64'h0, "R5");
    end

    // Status outcomes (R7)
    fill_bytes(40);
    do_sector(128'h1, 4'd0, 2'd0, 3, 64'h0, 64'h0, "R7");
    do_sector(128'h1 << 80, 4'd1, 2'd2, 3, 64'h0, 64'h0, "R7");
    // Timeout boundary (R11)
    do_sector(128'h1, 4'd2, 2'd0, LIM, 64'h0000_0000_0000_0010, 64'h42, "R11");
    do_sector(128'h1, 4'd2, 2'd0, LIM + 1, 64'h0000_0000_0000_0010, 64'h42, "R11");

    // Raw address sweep, single error (R9)
    for (int raw = 0; raw < 1024; raw++) begin
      logic [63:0] ea = {32'hDEAD_BEEF, 16'h1234, 6'b101010, 10'(raw)};
      logic [63:0] ev = {48'hCAFE_F00D_5555, 8'h99, 8'(raw) ^ 8'h5A};
      do_sector(128'h4, (raw % 2) ? 4'd3 : 4'd2, 2'd0, 1 + raw % 4, ea, ev, "R9");
    end

    // Error counts 1..4 with back-pressure (R8, R10, R12)
    bp_on = 1;
    for (int c = 0; c < 4; c++)
      for (int p = 0; p < 3; p++) begin
        logic [63:0] ea = {16'(7 + 100 * p), 16'(300 + p), 16'(519 - p), 16'(8 + 3 * p)};
        logic [63:0] ev = {32'h11C4_22B3 ^ 32'(p), 32'h33A2_4491 + 32'(p)};
        if (p == 2) ea[47:32] = 16'd600;
        do_sector(128'h8000, (p % 2) ? 4'd3 : 4'd2, 2'(c), 2, ea, ev, "R8");
      end
    bp_on = 0;

    if (!summary_done) begin
      summary_done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!summary_done) begin
      summary_done = 1;
      checks++; errors++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule